// File: doc/BRIEF.md
# MDIO Station Management Controller

This block runs PHY management transactions on the two-wire MDC/MDIO bus on behalf of software. Software uses a small register port to set a clock divider and load the outgoing data word. It then writes a command word that holds the PHY address, the register address, the operation and a go bit. The block sends one complete frame: a run of ones as preamble, the start code, the opcode, both addresses, the turnaround and sixteen data bits. It drives MDC from a divided system clock while it does so.

For a write, the master drives MDIO for the whole frame. For a read, it releases MDIO from the turnaround onward and shifts in the sixteen data bits that the PHY returns. The busy flag in the command register stays set until the last MDC falling edge of the frame. When busy clears, read data is in the data register. If the command asked for it, a single-cycle interrupt pulse marks completion. While a frame runs, the block ignores every register write, so the frame cannot be corrupted in mid-flight.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset, busy reads 0, MDC is low, MDIO is released (`mdio_oe`=0), `irq` is 0, the command fields read 0, the data register reads 0 and the divider reads `DIV_RESET` (19 by default).
- R2: The register port decodes three addresses. Address 0 is the command word: bit 0 go/busy, bit 1 write operation, bit 2 interrupt enable, bits 10:6 register address, bits 15:11 PHY address, bits 5:3 reading as 0. Address 1 is the 16-bit data word. Address 2 holds the divider in bits 5:0. Address 3 reads 0. Reads are combinational from `reg_addr`.
- R3: While a frame runs, MDC has a period of 2·(div+1) system clocks. It stays low for the first div+1 cycles after the command is accepted. When idle it is held low.
- R4: The bits of a frame, MSB first, are: 32 ones, then 01, then opcode 10 for a read or 01 for a write, then the PHY address, then the register address, then the turnaround (10 on a write), then the data word on a write. Each bit is presented from the MDC falling edge that precedes it, and the first bit from the accepting edge.
- R5: A write drives MDIO for all 64 bits. A read drives bits 0 to 45 and releases MDIO from bit 46 (the turnaround) to the end.
- R6: On a read, `mdio_i` is sampled on the MDC rising edges of bits 48 to 63, MSB first. The 16-bit result is in the data register when busy clears.
- R7: A command write with bit 0 set while idle sets busy in the same clock. Busy clears on the falling MDC edge that ends bit 63, which is 128·(div+1) clocks after acceptance.
- R8: While busy, writes to the command, data and divider registers are ignored.
- R9: When a frame with interrupt enable set completes, `irq` is high for exactly the one cycle after busy clears. Otherwise `irq` stays low.
- R10: A write frame leaves the data register unchanged.
- R11: A command write with bit 0 clear while idle updates the command fields without starting a frame. MDC stays low and MDIO stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO value seen on the pad |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| irq | output | 1 | Completion pulse |

## Verification
The bench drives frames at divider values 0, 1 and 3 and compares MDC, the MDIO drive and enable, `irq` and the register readback against a reference model on every clock. An off-by-one in the divider would show up as a stretched or shrunk MDC phase, and a late turnaround release as a clash with the PHY at bit 46. Read words of 3C96 and 8001 exercise the first and last captured bits, so a capture on the wrong edge or a shift in the wrong direction shows up as a mangled read value. Writes to the command, divider and data registers are issued in mid-frame; a design that honoured them would change the readback or the waveform. A command with the go bit clear checks that the fields load while MDC stays parked.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int REG_W  = 16;
  localparam int PHYA_W = 5;
  localparam int REGA_W = 5;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CMD_GO_B     = 0;
  localparam int CMD_WR_B     = 1;
  localparam int CMD_IE_B     = 2;
  localparam int CMD_REGA_LSB = 6;
  localparam int CMD_PHYA_LSB = 11;

  localparam logic [1:0] FR_SOF   = 2'b01;
  localparam logic [1:0] FR_OP_RD = 2'b10;
  localparam logic [1:0] FR_OP_WR = 2'b01;
  localparam logic [1:0] FR_TA_WR = 2'b10;

  typedef struct packed {
    logic [PHYA_W-1:0] phy;
    logic [REGA_W-1:0] rega;
    logic              wr;
    logic              ie;
  } cmd_t;
endpackage

// File: rtl/mdio_regs.sv
`timescale 1ns/1ps
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int               DIV_W     = 6,
  parameter logic [DIV_W-1:0] DIV_RESET = DIV_W'(19)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_i,
  output logic              busy_o,
  output logic              start_o,
  output cmd_t              cmd_o,
  output cmd_t              cmd_load_o,
  output logic [DATA_W-1:0] data_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic              wr_idle, cmd_we;
  cmd_t              cmd_q, cmd_d, cmd_load;
  logic [DATA_W-1:0] data_q, data_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              busy_q, busy_d;
  logic              irq_q, irq_d;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata[CMD_REGA_LSB-1:CMD_IE_B+1];

  always_comb begin
    sel           = reg_sel_e'(reg_addr);
    wr_idle       = reg_wr && !busy_q;
    cmd_load.phy  = reg_wdata[CMD_PHYA_LSB +: PHYA_W];
    cmd_load.rega = reg_wdata[CMD_REGA_LSB +: REGA_W];
    cmd_load.wr   = reg_wdata[CMD_WR_B];
    cmd_load.ie   = reg_wdata[CMD_IE_B];
    cmd_we        = wr_idle && (sel == SEL_CMD);
    start_o       = cmd_we && reg_wdata[CMD_GO_B];
    cmd_d         = cmd_we ? cmd_load : cmd_q;

    if (done_i && !cmd_q.wr)
      data_d = rx_i;
    else if (wr_idle && (sel == SEL_DATA))
      data_d = reg_wdata[DATA_W-1:0];
    else
      data_d = data_q;

    div_d  = (wr_idle && (sel == SEL_CTRL)) ? reg_wdata[DIV_W-1:0] : div_q;
    busy_d = start_o ? 1'b1 : (done_i ? 1'b0 : busy_q);
    irq_d  = done_i && cmd_q.ie;
  end

  always_comb begin
    case (sel)
      SEL_CMD:  reg_rdata = {cmd_q.phy, cmd_q.rega, 3'b000, cmd_q.ie, cmd_q.wr, busy_q};
      SEL_DATA: reg_rdata = data_q;
      SEL_CTRL: reg_rdata = {{(REG_W-DIV_W){1'b0}}, div_q};
      default:  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      div_q  <= DIV_RESET;
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      data_q <= data_d;
      div_q  <= div_d;
      busy_q <= busy_d;
      irq_q  <= irq_d;
    end
  end

  assign busy_o     = busy_q;
  assign cmd_o      = cmd_q;
  assign cmd_load_o = cmd_load;
  assign data_o     = data_q;
  assign div_o      = div_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             flip;

  always_comb begin
    flip   = run_i && (cnt_q == div_i);
    rise_o = flip && !mdc_q;
    fall_o = flip && mdc_q;
    if (!run_i) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (flip) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
      mdc_d = mdc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc_o = mdc_q;
endmodule

// File: rtl/mdio_frame.sv
`timescale 1ns/1ps
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  localparam int FRAME_LEN = PRE_LEN + 4 + PHYA_W + REGA_W + 2 + DATA_W,
  localparam int IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  cmd_t              cmd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              wr_o
);
  localparam int TA_IDX   = PRE_LEN + 4 + PHYA_W + REGA_W;
  localparam int DATA_IDX = TA_IDX + 2;

  logic [FRAME_LEN-1:0] tx_q, tx_d, frame_img;
  logic [IDX_W-1:0]     idx_q, idx_d, idx_nxt;
  logic                 oe_q, oe_d;
  logic                 wr_q, wr_d;
  logic [DATA_W-1:0]    rx_q, rx_d;
  logic                 last_bit;

  always_comb begin
    frame_img = {{PRE_LEN{1'b1}}, FR_SOF,
                 cmd_i.wr ? FR_OP_WR : FR_OP_RD,
                 cmd_i.phy, cmd_i.rega,
                 cmd_i.wr ? FR_TA_WR : 2'b00,
                 cmd_i.wr ? data_i : {DATA_W{1'b0}}};
    last_bit = (idx_q == IDX_W'(FRAME_LEN-1));
    idx_nxt  = idx_q + IDX_W'(1);
    done_o   = fall_i && last_bit;
    tx_d  = tx_q;
    idx_d = idx_q;
    oe_d  = oe_q;
    wr_d  = wr_q;
    rx_d  = rx_q;
    if (start_i) begin
      tx_d  = frame_img;
      idx_d = '0;
      oe_d  = 1'b1;
      wr_d  = cmd_i.wr;
    end else if (fall_i) begin
      if (last_bit) begin
        oe_d = 1'b0;
      end else begin
        idx_d = idx_nxt;
        tx_d  = {tx_q[FRAME_LEN-2:0], 1'b0};
        oe_d  = wr_q || (idx_nxt < IDX_W'(TA_IDX));
      end
    end else if (rise_i && !wr_q && (idx_q >= IDX_W'(DATA_IDX))) begin
      rx_d = {rx_q[DATA_W-2:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      idx_q <= '0;
      oe_q  <= 1'b0;
      wr_q  <= 1'b0;
      rx_q  <= '0;
    end else begin
      tx_q  <= tx_d;
      idx_q <= idx_d;
      oe_q  <= oe_d;
      wr_q  <= wr_d;
      rx_q  <= rx_d;
    end
  end

  assign mdio_o  = oe_q & tx_q[FRAME_LEN-1];
  assign mdio_oe = oe_q;
  assign rx_o    = rx_q;
  assign idx_o   = idx_q;
  assign wr_o    = wr_q;
endmodule

// File: rtl/mdio_mgmt.sv
`timescale 1ns/1ps
module mdio_mgmt
  import mdio_pkg::*;
#(
  parameter int               DIV_W     = 6,
  parameter logic [DIV_W-1:0] DIV_RESET = DIV_W'(19),
  parameter int               PRE_LEN   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        irq
);
  localparam int FRAME_LEN = PRE_LEN + 4 + PHYA_W + REGA_W + 2 + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TA_IDX    = PRE_LEN + 4 + PHYA_W + REGA_W;

  logic [1:0]        rst_pipe;
  logic              rst_n_s;
  logic              busy, start, done, rise, fall, frm_wr;
  cmd_t              cmd_cur, cmd_load;
  logic [DATA_W-1:0] data_val, rx_val;
  logic [DIV_W-1:0]  div_val;
  logic [IDX_W-1:0]  bit_idx;
  logic [REG_W-1:0]  cmd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s  = rst_pipe[1];
  assign cmd_word = {cmd_cur.phy, cmd_cur.rega, 3'b000, cmd_cur.ie, cmd_cur.wr, 1'b0};

  mdio_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done_i(done), .rx_i(rx_val),
    .busy_o(busy), .start_o(start), .cmd_o(cmd_cur), .cmd_load_o(cmd_load),
    .data_o(data_val), .div_o(div_val), .irq_o(irq)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n_s), .run_i(busy), .div_i(div_val),
    .mdc_o(mdc), .rise_o(rise), .fall_o(fall)
  );

  mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk(clk), .rst_n(rst_n_s), .start_i(start), .cmd_i(cmd_load), .data_i(data_val),
    .rise_i(rise), .fall_i(fall), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done_o(done), .rx_o(rx_val), .idx_o(bit_idx), .wr_o(frm_wr)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_chk #(
  parameter int DIV_W  = 6,
  parameter int IDX_W  = 6,
  parameter int TA_IDX = 46
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mdc,
  input logic             oe,
  input logic             irq,
  input logic             frame_wr,
  input logic [IDX_W-1:0] bit_idx,
  input logic [DIV_W-1:0] div,
  input logic [15:0]      cmd_word
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !oe)); // R3
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!mdc && oe)); // R7
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_wr && (bit_idx >= IDX_W'(TA_IDX))) |-> !oe); // R5
  AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frame_wr) |-> oe); // R5
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R9
  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $fell(busy)); // R9
  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cmd_word) && $stable(div))); // R8
endmodule

bind mdio_mgmt mdio_mgmt_chk #(.DIV_W(DIV_W), .IDX_W(IDX_W), .TA_IDX(TA_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .busy(busy), .mdc(mdc), .oe(mdio_oe), .irq(irq),
  .frame_wr(frm_wr), .bit_idx(bit_idx), .div(div_val), .cmd_word(cmd_word)
);

// File: tb/mdio_mgmt_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_bench;
  localparam int NBITS = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_addr;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_i, mdio_o, mdio_oe, irq;

  always #2.5 clk = ~clk;

  mdio_mgmt u_mdio_mgmt (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .irq(irq)
  );

  int checks = 0;
  int fails = 0;
  int irq_seen = 0;
  bit finished = 0;

  bit        m_busy, m_wr, m_ie, m_irq;
  int        m_t;
  bit [4:0]  m_phy, m_rega;
  bit [15:0] m_data, phy_val;
  bit [5:0]  m_div;
  bit        m_frame[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] cmdw(input int phy, input int rega, input bit ie,
                                       input bit wr, input bit go);
    logic [4:0] p = 5'(phy);
    logic [4:0] r = 5'(rega);
    return {p, r, 3'b000, ie, wr, go};
  endfunction

  task automatic model_reset();
    m_busy = 0; m_wr = 0; m_ie = 0; m_irq = 0; m_t = 0;
    m_phy = 0; m_rega = 0; m_data = 0; m_div = 6'd19;
    m_frame.delete();
  endtask

  task automatic build_frame();
    m_frame.delete();
    for (int i = 0; i < 32; i++) m_frame.push_back(1'b1);
    m_frame.push_back(1'b0); m_frame.push_back(1'b1);
    m_frame.push_back(!m_wr); m_frame.push_back(m_wr);
    for (int i = 4; i >= 0; i--) m_frame.push_back(m_phy[i]);
    for (int i = 4; i >= 0; i--) m_frame.push_back(m_rega[i]);
    m_frame.push_back(m_wr); m_frame.push_back(1'b0);
    for (int i = 15; i >= 0; i--) m_frame.push_back(m_wr ? m_data[i] : 1'b0);
  endtask

  task automatic model_step();
    m_irq = 0;
    if (m_busy) begin
      m_t++;
      if (m_t == NBITS * 2 * (int'(m_div) + 1)) begin
        m_busy = 0;
        m_irq = m_ie;
        if (!m_wr) m_data = phy_val;
      end
    end else if (reg_wr) begin
      case (reg_addr)
        2'd0: begin
          m_phy = reg_wdata[15:11]; m_rega = reg_wdata[10:6];
          m_ie = reg_wdata[2]; m_wr = reg_wdata[1];
          if (reg_wdata[0]) begin
            m_busy = 1; m_t = 0;
            build_frame();
          end
        end
        2'd1: m_data = reg_wdata;
        2'd2: m_div = reg_wdata[5:0];
        default: ;
      endcase
    end
  endtask

  function automatic int cur_bit();
    return m_t / (2 * (int'(m_div) + 1));
  endfunction

  function automatic logic [15:0] exp_rdata();
    case (reg_addr)
      2'd0: return {m_phy, m_rega, 3'b000, m_ie, m_wr, m_busy};
      2'd1: return m_data;
      2'd2: return {10'd0, m_div};
      default: return 16'd0;
    endcase
  endfunction

  task automatic compare_outputs();
    bit e_mdc, e_oe, e_o;
    e_mdc = 0; e_oe = 0; e_o = 0;
    if (m_busy) begin
      e_mdc = ((m_t / (int'(m_div) + 1)) % 2) == 1;
      e_oe  = m_wr || (cur_bit() < 46);
      e_o   = e_oe ? m_frame[cur_bit()] : 1'b0;
    end
    chk("R3 mdc", 32'(mdc), 32'(e_mdc));
    chk("R5 mdio_oe", 32'(mdio_oe), 32'(e_oe));
    if (e_oe) chk("R4 mdio_o", 32'(mdio_o), 32'(e_o));
    chk("R9 irq", 32'(irq), 32'(m_irq));
    chk("R2 reg_rdata", 32'(reg_rdata), 32'(exp_rdata()));
    if (irq) irq_seen++;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
    #2;
    if (!finished) compare_outputs();
  end

  // PHY model: returns phy_val during the read data bits, pull-up otherwise (R6)
  always @(negedge clk) begin
    if (m_busy && !m_wr && cur_bit() >= 48)
      mdio_i <= phy_val[15 - (cur_bit() - 48)];
    else
      mdio_i <= 1'b1;
  end

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired act=running exp=done");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 16'd0; phy_val = 16'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    peek(2'd0, 16'h0000, "R1 cmd after reset");
    peek(2'd1, 16'h0000, "R1 data after reset");
    peek(2'd2, 16'd19, "R1 divider after reset");
    chk("R1 mdc low", 32'(mdc), 32'd0);
    chk("R1 mdio released", 32'(mdio_oe), 32'd0);
    chk("R1 irq low", 32'(irq), 32'd0);
    peek(2'd3, 16'h0000, "R2 unused address");

    // R2 divider and data readback, then a write frame (R4 R7 R10)
    wr_reg(2'd2, 16'd1);
    peek(2'd2, 16'd1, "R2 divider readback");
    wr_reg(2'd1, 16'hA5C3);
    peek(2'd1, 16'hA5C3, "R2 data readback");
    wr_reg(2'd0, cmdw(5, 26, 1, 1, 1));
    peek(2'd0, cmdw(5, 26, 1, 1, 1), "R7 busy set on accept");
    wait_idle();
    peek(2'd0, cmdw(5, 26, 1, 1, 0), "R7 busy cleared");
    peek(2'd1, 16'hA5C3, "R10 data kept after write");
    chk("R9 one pulse with enable", 32'(irq_seen), 32'd1);

    // read frame with mid-frame writes ignored (R6 R8)
    phy_val = 16'h3C96;
    wr_reg(2'd0, cmdw(1, 1, 0, 0, 1));
    wr_reg(2'd0, cmdw(9, 9, 1, 1, 1));
    wr_reg(2'd1, 16'h1234);
    wr_reg(2'd2, 16'd7);
    peek(2'd0, cmdw(1, 1, 0, 0, 1), "R8 cmd write ignored");
    peek(2'd2, 16'd1, "R8 divider write ignored");
    wait_idle();
    peek(2'd1, 16'h3C96, "R6 read data captured");
    chk("R9 no pulse without enable", 32'(irq_seen), 32'd1);

    // fastest divider, extreme addresses and edge data bits (R3 R6)
    wr_reg(2'd2, 16'd0);
    phy_val = 16'h8001;
    wr_reg(2'd0, cmdw(31, 31, 1, 0, 1));
    wait_idle();
    peek(2'd1, 16'h8001, "R6 read edge bits");
    chk("R9 pulse on read", 32'(irq_seen), 32'd2);

    // slower divider write of all ones (R3 R4 R10)
    wr_reg(2'd2, 16'd3);
    wr_reg(2'd1, 16'hFFFF);
    wr_reg(2'd0, cmdw(0, 0, 0, 1, 1));
    wait_idle();
    peek(2'd1, 16'hFFFF, "R10 data kept after write");

    // R11 fields without go
    wr_reg(2'd0, cmdw(3, 4, 1, 0, 0));
    peek(2'd0, cmdw(3, 4, 1, 0, 0), "R11 fields loaded, not busy");
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R11 mdc parked", 32'(mdc), 32'd0);
      chk("R11 mdio released", 32'(mdio_oe), 32'd0);
    end
    report();
  end
endmodule